// File: doc/BRIEF.md
# Bufferless Fat-Tree Router Node

This block is one switching node of a binary fat-tree on-chip network. It stores no flits and has no crossbar. Each packet moves wormhole-style, one flit per cycle. The first valid flit of a packet is its header. The low `AW` bits of the header hold the destination client address. Three comparators check that address against constants fixed at elaboration from the node's row `ROW` and column `COL`:

- the base `B = floor(COL / 2^ROW) * 2^ROW`;
- the split point `S = B + 2^(ROW-1)`;
- the limit `E = B + 2^ROW`.

Addresses in `[B,S)` belong to the left subtree, `[S,E)` to the right subtree, and all others lie above the node.

The node has three groups of input lanes:

- `NP = 2*NC` lanes from the parent side;
- `NC` lanes from the left child;
- `NC` lanes from the right child.

Downward capacity is doubled so that no two inputs can ever want the same output. Each parent lane `p` owns left output `p` and right output `p`. Left-child lane `c` owns right output `NP+c`. Right-child lane `c` owns left output `NP+c`. Only the `NP` upward links are shared. A child header bound upward takes a free up link chosen on the spot.

Once a header is decoded, the lane keeps its path until the flit flagged last has passed. The path is then free from the next cycle on. Flits cross the node in the same cycle they arrive, with data unchanged. There is no backpressure.

Top module: `fatr_router`

## Requirements
- R1: A parent-lane header `p` with address in `[B,S)` appears on left output `p` in the same cycle, with data unchanged.
- R2: A parent-lane header `p` with address in `[S,E)` appears on right output `p`.
- R3: A parent-lane packet whose header address lies outside `[B,S) ∪ [S,E)` is discarded whole. No output shows valid for any of its flits.
- R4: A left-child header `c` with address in `[S,E)` goes to right output `NP+c`. A right-child header `c` with address in `[B,S)` goes to left output `NP+c`.
- R5: A child header with address outside `[B,E)` takes the lowest-numbered up link that no packet currently holds.
- R6: When several child headers need an up link in the same cycle, they are served in requester order and each takes the next free link. Requester order is left-child lanes `0..NC-1`, then right-child lanes `0..NC-1`.
- R7: A child packet whose address falls inside the half-range of that same child is discarded whole.
- R8: The path chosen by a header holds for every later flit up to and including the last one. The address bits of body flits have no effect.
- R9: An output shows valid only in a cycle where its owning input lane is valid. A bubble (valid low) inside a packet yields valid low on the held output.
- R10: A held up link is still busy in the cycle of its packet's last flit. It is free for a new header from the following cycle.
- R11: All parent lanes, and child lanes turning across, can pass flits in the same cycle with no lane blocked.
- R12: During reset, and with all inputs idle, every output valid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| par_i_vld | input | NP | Parent-side lane flit valid |
| par_i_dat | input | NP*FW | Parent-side lane flit data, address in low AW bits of header |
| par_i_lst | input | NP | Parent-side lane last-flit flag |
| lc_i_vld | input | NC | Left-child lane flit valid |
| lc_i_dat | input | NC*FW | Left-child lane flit data |
| lc_i_lst | input | NC | Left-child lane last-flit flag |
| rc_i_vld | input | NC | Right-child lane flit valid |
| rc_i_dat | input | NC*FW | Right-child lane flit data |
| rc_i_lst | input | NC | Right-child lane last-flit flag |
| up_o_vld | output | NP | Up link flit valid |
| up_o_dat | output | NP*FW | Up link flit data |
| lt_o_vld | output | NP+NC | Left-child-side output valid |
| lt_o_dat | output | (NP+NC)*FW | Left-child-side output data |
| rt_o_vld | output | NP+NC | Right-child-side output valid |
| rt_o_dat | output | (NP+NC)*FW | Right-child-side output data |

## Verification
The bench probes each edge of the address windows: `B-1`, `B`, `S-1`, `S`, `E-1` and `E`. An off-by-one comparator would send such a flit the wrong way or drop it. Several sequences check the holding of paths:

- a body flit whose address bits point elsewhere; a wrong design would re-decode it and switch sides;
- a bubble in the middle of a packet; a design that kept a stale valid would show a phantom flit;
- a dropped multi-flit packet; a design that forgot the drop would leak the body flits.

For the up links, simultaneous headers, a header arriving in the same cycle as another packet's last flit, and a header arriving in the cycle after that last flit expose any wrong priority and any release that comes one cycle early or one cycle late.

// File: rtl/fatr_pkg.sv
package fatr_pkg;
   typedef enum logic [1:0] {
      RT_LEFT  = 2'd0,
      RT_RIGHT = 2'd1,
      RT_UP    = 2'd2,
      RT_DROP  = 2'd3
   } route_e;
endpackage

// File: rtl/fatr_range_dec.sv
module fatr_range_dec
   import fatr_pkg::*;
#(
   parameter int AW   = 6,
   parameter int ROW  = 2,
   parameter int COL  = 5,
   parameter int SIDE = 0   // 0 parent side, 1 left child, 2 right child
) (
   input  logic [AW-1:0] addr,
   output route_e        rt
);
   localparam int SPAN = 1 << ROW;
   localparam int BASE = (COL / SPAN) * SPAN;
   localparam int SPLT = BASE + SPAN / 2;
   localparam int LIM  = BASE + SPAN;
   localparam logic [AW:0] BASE_V = (AW+1)'(BASE);
   localparam logic [AW:0] SPLT_V = (AW+1)'(SPLT);
   localparam logic [AW:0] LIM_V  = (AW+1)'(LIM);

   logic [AW:0] a_ext;
   logic        ge_base, ge_splt, ge_lim;
   logic        in_lo, in_hi;

   assign a_ext   = {1'b0, addr};
   assign ge_base = (a_ext >= BASE_V);
   assign ge_splt = (a_ext >= SPLT_V);
   assign ge_lim  = (a_ext >= LIM_V);
   assign in_lo   = ge_base & ~ge_splt;
   assign in_hi   = ge_splt & ~ge_lim;

   generate
      if (SIDE == 0) begin : g_par
         always_comb begin
            if (in_lo)      rt = RT_LEFT;
            else if (in_hi) rt = RT_RIGHT;
            else            rt = RT_DROP;
         end
      end else if (SIDE == 1) begin : g_lc
         always_comb begin
            if (in_hi)      rt = RT_RIGHT;
            else if (in_lo) rt = RT_DROP;
            else            rt = RT_UP;
         end
      end else begin : g_rc
         always_comb begin
            if (in_lo)      rt = RT_LEFT;
            else if (in_hi) rt = RT_DROP;
            else            rt = RT_UP;
         end
      end
   endgenerate
endmodule

// File: rtl/fatr_lane.sv
module fatr_lane
   import fatr_pkg::*;
#(
   parameter int AW   = 6,
   parameter int UW   = 2,
   parameter int ROW  = 2,
   parameter int COL  = 5,
   parameter int SIDE = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          vld,
   input  logic [AW-1:0] addr,
   input  logic          lst,
   input  logic [UW-1:0] grant,
   output route_e        eff_rt,
   output logic [UW-1:0] eff_up,
   output logic          hdr_up,
   output logic          held_up,
   output logic [UW-1:0] held_idx
);
   route_e        dec_rt;
   route_e        dir_q;
   logic          act_q;
   logic [UW-1:0] uidx_q;

   fatr_range_dec #(.AW(AW), .ROW(ROW), .COL(COL), .SIDE(SIDE)) u_dec (
      .addr (addr),
      .rt   (dec_rt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         dir_q  <= RT_DROP;
         uidx_q <= '0;
      end else if (vld) begin
         if (!act_q) begin
            if (!lst) begin
               act_q  <= 1'b1;
               dir_q  <= dec_rt;
               uidx_q <= grant;
            end
         end else if (lst) begin
            act_q <= 1'b0;
         end
      end
   end

   assign eff_rt   = act_q ? dir_q : dec_rt;
   assign eff_up   = act_q ? uidx_q : grant;
   assign hdr_up   = vld & ~act_q & (dec_rt == RT_UP);
   assign held_up  = act_q & (dir_q == RT_UP);
   assign held_idx = uidx_q;
endmodule

// File: rtl/fatr_up_alloc.sv
module fatr_up_alloc #(
   parameter int NREQ = 4,
   parameter int NLNK = 4,
   parameter int UW   = 2
) (
   input  logic [NREQ-1:0] req,
   input  logic [NLNK-1:0] busy,
   output logic [UW-1:0]   gnt [NREQ]
);
   logic [NLNK-1:0] taken;
   logic            hit;

   always_comb begin
      taken = busy;
      hit   = 1'b0;
      for (int i = 0; i < NREQ; i++) begin
         gnt[i] = '0;
         hit    = 1'b0;
         if (req[i]) begin
            for (int j = 0; j < NLNK; j++) begin
               if (!hit && !taken[j]) begin
                  gnt[i]   = UW'(j);
                  taken[j] = 1'b1;
                  hit      = 1'b1;
               end
            end
         end
      end
   end
endmodule

// File: rtl/fatr_router.sv
module fatr_router
   import fatr_pkg::*;
#(
   parameter int NC  = 2,
   parameter int FW  = 16,
   parameter int AW  = 6,
   parameter int ROW = 2,
   parameter int COL = 5
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [2*NC-1:0]          par_i_vld,
   input  logic [2*NC-1:0][FW-1:0]  par_i_dat,
   input  logic [2*NC-1:0]          par_i_lst,
   input  logic [NC-1:0]            lc_i_vld,
   input  logic [NC-1:0][FW-1:0]    lc_i_dat,
   input  logic [NC-1:0]            lc_i_lst,
   input  logic [NC-1:0]            rc_i_vld,
   input  logic [NC-1:0][FW-1:0]    rc_i_dat,
   input  logic [NC-1:0]            rc_i_lst,
   output logic [2*NC-1:0]          up_o_vld,
   output logic [2*NC-1:0][FW-1:0]  up_o_dat,
   output logic [3*NC-1:0]          lt_o_vld,
   output logic [3*NC-1:0][FW-1:0]  lt_o_dat,
   output logic [3*NC-1:0]          rt_o_vld,
   output logic [3*NC-1:0][FW-1:0]  rt_o_dat
);
   localparam int NP   = 2 * NC;
   localparam int NCH  = 2 * NC;
   localparam int UW   = (NP > 1) ? $clog2(NP) : 1;
   localparam int SPAN = 1 << ROW;
   localparam int LIM  = (COL / SPAN) * SPAN + SPAN;

   generate
      if (NC < 1)          begin : g_bad_nc  $error("NC must be at least 1");       end
      if (ROW < 1)         begin : g_bad_row $error("ROW must be at least 1");      end
      if (FW < AW)         begin : g_bad_fw  $error("FW must hold the address");    end
      if (LIM > (1 << AW)) begin : g_bad_aw  $error("AW too narrow for the range"); end
   endgenerate

   route_e        par_rt  [NP];
   logic [UW-1:0] par_up  [NP];
   logic          par_hup [NP];
   logic          par_hld [NP];
   logic [UW-1:0] par_hix [NP];

   route_e          ch_rt  [NCH];
   logic [UW-1:0]   ch_up  [NCH];
   logic [NCH-1:0]  ch_req;
   logic            ch_hld [NCH];
   logic [UW-1:0]   ch_hix [NCH];
   logic [UW-1:0]   ch_gnt [NCH];
   logic [NP-1:0]   up_busy;

   genvar gi;
   generate
      for (gi = 0; gi < NP; gi++) begin : g_par
         fatr_lane #(.AW(AW), .UW(UW), .ROW(ROW), .COL(COL), .SIDE(0)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .vld      (par_i_vld[gi]),
            .addr     (par_i_dat[gi][AW-1:0]),
            .lst      (par_i_lst[gi]),
            .grant    ('0),
            .eff_rt   (par_rt[gi]),
            .eff_up   (par_up[gi]),
            .hdr_up   (par_hup[gi]),
            .held_up  (par_hld[gi]),
            .held_idx (par_hix[gi])
         );
      end
      for (gi = 0; gi < NC; gi++) begin : g_lc
         fatr_lane #(.AW(AW), .UW(UW), .ROW(ROW), .COL(COL), .SIDE(1)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .vld      (lc_i_vld[gi]),
            .addr     (lc_i_dat[gi][AW-1:0]),
            .lst      (lc_i_lst[gi]),
            .grant    (ch_gnt[gi]),
            .eff_rt   (ch_rt[gi]),
            .eff_up   (ch_up[gi]),
            .hdr_up   (ch_req[gi]),
            .held_up  (ch_hld[gi]),
            .held_idx (ch_hix[gi])
         );
      end
      for (gi = 0; gi < NC; gi++) begin : g_rc
         fatr_lane #(.AW(AW), .UW(UW), .ROW(ROW), .COL(COL), .SIDE(2)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .vld      (rc_i_vld[gi]),
            .addr     (rc_i_dat[gi][AW-1:0]),
            .lst      (rc_i_lst[gi]),
            .grant    (ch_gnt[NC+gi]),
            .eff_rt   (ch_rt[NC+gi]),
            .eff_up   (ch_up[NC+gi]),
            .hdr_up   (ch_req[NC+gi]),
            .held_up  (ch_hld[NC+gi]),
            .held_idx (ch_hix[NC+gi])
         );
      end
   endgenerate

   // links held by packets already in flight
   always_comb begin
      up_busy = '0;
      for (int k = 0; k < NCH; k++)
         if (ch_hld[k]) up_busy[ch_hix[k]] = 1'b1;
   end

   fatr_up_alloc #(.NREQ(NCH), .NLNK(NP), .UW(UW)) u_alloc (
      .req  (ch_req),
      .busy (up_busy),
      .gnt  (ch_gnt)
   );

   always_comb begin
      up_o_vld = '0;
      up_o_dat = '0;
      lt_o_vld = '0;
      lt_o_dat = '0;
      rt_o_vld = '0;
      rt_o_dat = '0;
      for (int p = 0; p < NP; p++) begin
         if (par_i_vld[p]) begin
            case (par_rt[p])
               RT_LEFT: begin
                  lt_o_vld[p] = 1'b1;
                  lt_o_dat[p] = par_i_dat[p];
               end
               RT_RIGHT: begin
                  rt_o_vld[p] = 1'b1;
                  rt_o_dat[p] = par_i_dat[p];
               end
               default: ;
            endcase
         end
      end
      for (int c = 0; c < NC; c++) begin
         if (lc_i_vld[c]) begin
            case (ch_rt[c])
               RT_RIGHT: begin
                  rt_o_vld[NP+c] = 1'b1;
                  rt_o_dat[NP+c] = lc_i_dat[c];
               end
               RT_UP: begin
                  up_o_vld[ch_up[c]] = 1'b1;
                  up_o_dat[ch_up[c]] = lc_i_dat[c];
               end
               default: ;
            endcase
         end
         if (rc_i_vld[c]) begin
            case (ch_rt[NC+c])
               RT_LEFT: begin
                  lt_o_vld[NP+c] = 1'b1;
                  lt_o_dat[NP+c] = rc_i_dat[c];
               end
               RT_UP: begin
                  up_o_vld[ch_up[NC+c]] = 1'b1;
                  up_o_dat[ch_up[NC+c]] = rc_i_dat[c];
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/fatr_router_chk.sv
module fatr_router_chk #(
   parameter int NC  = 2,
   parameter int FW  = 16,
   parameter int AW  = 6,
   parameter int ROW = 2,
   parameter int COL = 5
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic [2*NC-1:0]          par_i_vld,
   input logic [2*NC-1:0][FW-1:0]  par_i_dat,
   input logic [2*NC-1:0]          par_i_lst,
   input logic [NC-1:0]            lc_i_vld,
   input logic [NC-1:0][FW-1:0]    lc_i_dat,
   input logic [NC-1:0]            lc_i_lst,
   input logic [NC-1:0]            rc_i_vld,
   input logic [NC-1:0][FW-1:0]    rc_i_dat,
   input logic [NC-1:0]            rc_i_lst,
   input logic [2*NC-1:0]          up_o_vld,
   input logic [2*NC-1:0][FW-1:0]  up_o_dat,
   input logic [3*NC-1:0]          lt_o_vld,
   input logic [3*NC-1:0][FW-1:0]  lt_o_dat,
   input logic [3*NC-1:0]          rt_o_vld,
   input logic [3*NC-1:0][FW-1:0]  rt_o_dat
);
   localparam int NP = 2 * NC;

   // R5: up links carry no more flits than child lanes present
   a_r5_up_from_children: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(up_o_vld) <= $countones({lc_i_vld, rc_i_vld}));

   genvar gp;
   generate
      for (gp = 0; gp < NP; gp++) begin : g_p
         // R9: a parent-owned output mirrors its own lane only
         a_r9_lt_owner: assert property (@(posedge clk) disable iff (!rst_n)
            lt_o_vld[gp] |-> (par_i_vld[gp] && lt_o_dat[gp] == par_i_dat[gp]));
         a_r9_rt_owner: assert property (@(posedge clk) disable iff (!rst_n)
            rt_o_vld[gp] |-> (par_i_vld[gp] && rt_o_dat[gp] == par_i_dat[gp]));
         // R11: one parent lane never splits onto both sides
         a_r11_one_side: assert property (@(posedge clk) disable iff (!rst_n)
            !(lt_o_vld[gp] && rt_o_vld[gp]));
         // R8: a held left path never turns right mid-packet
         a_r8_hold_left: assert property (@(posedge clk) disable iff (!rst_n)
            (lt_o_vld[gp] && !par_i_lst[gp]) |=> !rt_o_vld[gp]);
         // R3: a swallowed packet stays swallowed until its last flit
         a_r3_drop_kept: assert property (@(posedge clk) disable iff (!rst_n)
            (par_i_vld[gp] && !par_i_lst[gp] && !lt_o_vld[gp] && !rt_o_vld[gp])
            |=> (!lt_o_vld[gp] && !rt_o_vld[gp]));
      end
      for (gp = 0; gp < NC; gp++) begin : g_c
         // R4: turning outputs driven only by their own child lane
         a_r4_lt_turn: assert property (@(posedge clk) disable iff (!rst_n)
            lt_o_vld[NP+gp] |-> (rc_i_vld[gp] && lt_o_dat[NP+gp] == rc_i_dat[gp]));
         a_r4_rt_turn: assert property (@(posedge clk) disable iff (!rst_n)
            rt_o_vld[NP+gp] |-> (lc_i_vld[gp] && rt_o_dat[NP+gp] == lc_i_dat[gp]));
      end
   endgenerate
endmodule

bind fatr_router fatr_router_chk #(
   .NC(NC), .FW(FW), .AW(AW), .ROW(ROW), .COL(COL)
) u_chk (.*);

// File: tb/fatr_router_test.sv
module fatr_router_test;
   localparam int NC = 2;
   localparam int NP = 4;
   localparam int NO = 6;
   localparam int FW = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NP-1:0]         par_i_vld, par_i_lst;
   logic [NP-1:0][FW-1:0] par_i_dat;
   logic [NC-1:0]         lc_i_vld, lc_i_lst, rc_i_vld, rc_i_lst;
   logic [NC-1:0][FW-1:0] lc_i_dat, rc_i_dat;
   logic [NP-1:0]         up_o_vld;
   logic [NP-1:0][FW-1:0] up_o_dat;
   logic [NO-1:0]         lt_o_vld, rt_o_vld;
   logic [NO-1:0][FW-1:0] lt_o_dat, rt_o_dat;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   fatr_router #(.NC(NC), .FW(FW), .AW(6), .ROW(2), .COL(5)) uut (.*);

   // node constants for ROW=2, COL=5: base 4, split 6, limit 8
   // entry: {grp[1:0] 0 par 1 lc 2 rc, idx[2:0], addr[5:0], ogrp[1:0] 0 lt 1 rt 2 up 3 none, oidx[2:0]}
   localparam logic [15:0] VEC [16] = '{
      {2'd0, 3'd0, 6'd4,  2'd0, 3'd0},   // R1 base
      {2'd0, 3'd1, 6'd5,  2'd0, 3'd1},   // R1 split-1
      {2'd0, 3'd2, 6'd6,  2'd1, 3'd2},   // R2 split
      {2'd0, 3'd3, 6'd7,  2'd1, 3'd3},   // R2 limit-1
      {2'd0, 3'd0, 6'd3,  2'd3, 3'd0},   // R3 base-1
      {2'd0, 3'd1, 6'd8,  2'd3, 3'd0},   // R3 limit
      {2'd0, 3'd2, 6'd63, 2'd3, 3'd0},   // R3 top
      {2'd1, 3'd0, 6'd6,  2'd1, 3'd4},   // R4 lc turn
      {2'd1, 3'd1, 6'd7,  2'd1, 3'd5},   // R4
      {2'd2, 3'd0, 6'd4,  2'd0, 3'd4},   // R4 rc turn
      {2'd2, 3'd1, 6'd5,  2'd0, 3'd5},   // R4
      {2'd1, 3'd0, 6'd4,  2'd3, 3'd0},   // R7 own half
      {2'd2, 3'd1, 6'd7,  2'd3, 3'd0},   // R7 own half
      {2'd1, 3'd1, 6'd0,  2'd2, 3'd0},   // R5 up
      {2'd2, 3'd0, 6'd9,  2'd2, 3'd0},   // R5 up
      {2'd2, 3'd1, 6'd63, 2'd2, 3'd0}    // R5 up
   };

   function automatic logic [FW-1:0] mk(int grp, int idx, int addr);
      return FW'(16'hA000 | (grp << 10) | (idx << 7) | addr);
   endfunction

   task automatic idle();
      par_i_vld = '0; par_i_lst = '0; par_i_dat = '0;
      lc_i_vld = '0; lc_i_lst = '0; lc_i_dat = '0;
      rc_i_vld = '0; rc_i_lst = '0; rc_i_dat = '0;
   endtask

   task automatic drive(int grp, int idx, int addr, bit lst);
      case (grp)
         0: begin par_i_vld[idx] = 1'b1; par_i_lst[idx] = lst; par_i_dat[idx] = mk(grp, idx, addr); end
         1: begin lc_i_vld[idx] = 1'b1; lc_i_lst[idx] = lst; lc_i_dat[idx] = mk(grp, idx, addr); end
         default: begin rc_i_vld[idx] = 1'b1; rc_i_lst[idx] = lst; rc_i_dat[idx] = mk(grp, idx, addr); end
      endcase
   endtask

   task automatic chk_vld(logic [NO-1:0] elt, logic [NO-1:0] ert, logic [NP-1:0] eup, string tag);
      checks++;
      if (lt_o_vld !== elt || rt_o_vld !== ert || up_o_vld !== eup) begin
         errors++;
         $display("FAIL %s: lt/rt/up valid %b/%b/%b expected %b/%b/%b",
                  tag, lt_o_vld, rt_o_vld, up_o_vld, elt, ert, eup);
      end
   endtask

   task automatic chk_dat(logic [FW-1:0] act, logic [FW-1:0] exp, string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: data %h expected %h", tag, act, exp);
      end
   endtask

   initial begin
      idle();
      // R12: outputs quiet in reset
      @(negedge clk);
      chk_vld('0, '0, '0, "R12 reset");
      @(negedge clk);
      rst_n = 1'b1;
      #1 chk_vld('0, '0, '0, "R12 idle after reset");

      // table of single-flit packets: R1 R2 R3 R4 R5 R7
      for (int v = 0; v < 16; v++) begin
         logic [NO-1:0] elt, ert;
         logic [NP-1:0] eup;
         int g, ix, a, og, oi;
         g = int'(VEC[v][15:14]); ix = int'(VEC[v][13:11]); a = int'(VEC[v][10:5]);
         og = int'(VEC[v][4:3]); oi = int'(VEC[v][2:0]);
         @(negedge clk);
         idle();
         drive(g, ix, a, 1'b1);
         elt = '0; ert = '0; eup = '0;
         if (og == 0) elt[oi] = 1'b1;
         if (og == 1) ert[oi] = 1'b1;
         if (og == 2) eup[oi] = 1'b1;
         #1;
         chk_vld(elt, ert, eup, $sformatf("R1-table vector %0d", v));
         if (og == 0) chk_dat(lt_o_dat[oi], mk(g, ix, a), "R1 R4 data");
         if (og == 1) chk_dat(rt_o_dat[oi], mk(g, ix, a), "R2 R4 data");
         if (og == 2) chk_dat(up_o_dat[oi], mk(g, ix, a), "R5 data");
      end

      // R8 path hold, R9 bubble, R10 release on parent lane 1
      @(negedge clk); idle(); drive(0, 1, 4, 1'b0);
      #1 chk_vld(6'b000010, '0, '0, "R8 header left");
      @(negedge clk); idle(); drive(0, 1, 7, 1'b0);
      #1 chk_vld(6'b000010, '0, '0, "R8 body address ignored");
      chk_dat(lt_o_dat[1], mk(0, 1, 7), "R8 body data");
      @(negedge clk); idle();
      #1 chk_vld('0, '0, '0, "R9 bubble mid-packet");
      @(negedge clk); idle(); drive(0, 1, 6, 1'b1);
      #1 chk_vld(6'b000010, '0, '0, "R8 last flit held");
      @(negedge clk); idle(); drive(0, 1, 6, 1'b1);
      #1 chk_vld('0, 6'b000010, '0, "R10 new header after last");

      // R3 multi-flit drop swallowed whole
      @(negedge clk); idle(); drive(0, 0, 9, 1'b0);
      #1 chk_vld('0, '0, '0, "R3 drop header");
      @(negedge clk); idle(); drive(0, 0, 4, 1'b1);
      #1 chk_vld('0, '0, '0, "R3 drop body swallowed");
      @(negedge clk); idle(); drive(0, 0, 4, 1'b1);
      #1 chk_vld(6'b000001, '0, '0, "R3 lane usable after drop");

      // R6 simultaneous up headers: lc1 (req 1) before rc0 (req 2)
      @(negedge clk); idle(); drive(1, 1, 0, 1'b0); drive(2, 0, 12, 1'b0);
      #1 chk_vld('0, '0, 4'b0011, "R6 two up headers");
      chk_dat(up_o_dat[0], mk(1, 1, 0), "R6 lc1 on up0");
      chk_dat(up_o_dat[1], mk(2, 0, 12), "R6 rc0 on up1");
      // R5 lowest free while up0/up1 held
      @(negedge clk); idle(); drive(1, 1, 1, 1'b0); drive(2, 0, 1, 1'b0); drive(1, 0, 20, 1'b1);
      #1 chk_vld('0, '0, 4'b0111, "R5 lowest free link");
      chk_dat(up_o_dat[2], mk(1, 0, 20), "R5 lc0 on up2");
      // R10 link still busy during last flit
      @(negedge clk); idle(); drive(1, 1, 1, 1'b1); drive(2, 0, 1, 1'b0); drive(2, 1, 30, 1'b0);
      #1 chk_vld('0, '0, 4'b0111, "R10 busy during last");
      chk_dat(up_o_dat[2], mk(2, 1, 30), "R10 rc1 on up2");
      // R10 link free on the next cycle; rc1 bubble on up2
      @(negedge clk); idle(); drive(2, 0, 1, 1'b1); drive(1, 0, 40, 1'b1);
      #1 chk_vld('0, '0, 4'b0011, "R10 freed link reused");
      chk_dat(up_o_dat[0], mk(1, 0, 40), "R10 lc0 on up0");
      @(negedge clk); idle(); drive(2, 1, 2, 1'b1); drive(1, 1, 50, 1'b1);
      #1 chk_vld('0, '0, 4'b0101, "R5 lowest free after releases");
      chk_dat(up_o_dat[2], mk(2, 1, 2), "R8 rc1 held on up2");

      // R11 all lanes at once, no blocking
      @(negedge clk); idle();
      drive(0, 0, 4, 1'b1); drive(0, 1, 5, 1'b1); drive(0, 2, 6, 1'b1); drive(0, 3, 7, 1'b1);
      drive(1, 0, 6, 1'b1); drive(2, 1, 5, 1'b1);
      #1 chk_vld(6'b100011, 6'b011100, '0, "R11 concurrent lanes");

      @(negedge clk); idle();
      #1 chk_vld('0, '0, '0, "R9 idle after burst");
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #1_000_000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule